// File: doc/BRIEF.md
# Interleaved Reed-Solomon Frame Encoder

This block builds one 120-bit line frame from four 30-bit input words. The words arrive on a fast clock, four words per frame period. Each word gives 22 message bits, so the four words together give 88 bits: a 4-bit header and 84 payload bits. The encoder cuts these 88 bits into 22 four-bit symbols. It deals the symbols alternately to two Reed-Solomon codewords, A and B, over GF(16). Each codeword has 15 symbols: 11 data symbols and 4 parity symbols. The encoder computes the four parity symbols of each codeword. It then places the 30 symbols of both codewords, interleaved, into the frame.

Interleaving puts the line symbols of A and B in alternate positions. Each codeword corrects two symbol errors, so damage that falls on up to four adjacent line symbols stays correctable. The finished frame is held in an output register with a valid/ready handshake. From there it goes to the serializer. The message symbols pass through unchanged, so a receiver can use them without decoding.

Top module: `rs_frame_encoder`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_frame` is all zeros until a frame completes.
- R2: The message field is `out_frame[119:32] = {W0[21:0], W1[21:0], W2[21:0], W3[21:0]}`, where W0 is the first word of the frame. The header is `out_frame[119:116]`. Bits [29:22] of every word have no effect on the output.
- R3: Symbol position p runs from 0 to 29 and covers `out_frame[119-4p -: 4]`. An even p belongs to codeword A and an odd p to codeword B. Within its codeword, the symbol has index p/2 and is the coefficient of x^(14 - p/2).
- R4: Field arithmetic is GF(16) with the reduction polynomial x^4+x+1. A symbol value has bit i as the coefficient of x^i, and alpha = 4'h2. Each codeword is systematic: its parity is the remainder of m(x)·x^4 divided by g(x) = (x+alpha)(x+alpha^2)(x+alpha^3)(x+alpha^4). The parity nibbles are laid out as `out_frame[31:0] = {A3,B3,A2,B2,A1,B1,A0,B0}`, where Ak is the coefficient of x^k.
- R5: Both codewords of every output frame evaluate to zero at alpha, alpha^2, alpha^3 and alpha^4.
- R6: A word is taken only on a clock edge where `in_valid` is 1. An accepted word with `in_sof` = 1 becomes W0 and discards any partial frame. The frame completes on the fourth accepted word, and fewer than four words produce no frame.
- R7: `out_valid` and `out_frame` are updated at the same edge that samples W3. While `out_valid` is 1 and `out_ready` is 0, both stay unchanged.
- R8: A frame leaves at an edge where `out_valid` and `out_ready` are both 1. After that edge, `out_valid` is 0 unless another frame completes at that same edge. A frame that completes while the output is stalled is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input word qualifier |
| in_sof | input | 1 | Marks the first word of a frame |
| in_data | input | 30 | Input word; bits [21:0] carry message bits |
| out_ready | input | 1 | Downstream accepts the frame |
| out_valid | output | 1 | A frame is held on `out_frame` |
| out_frame | output | 120 | Encoded line frame |

## Verification
A frame appears on the outputs right after the edge that samples its fourth word, with no extra register stage. The bench drives each word at a falling edge and follows it with one idle cycle carrying junk data. It then reads the output at the falling edge right after the edge that took W3. Stall behaviour is read at falling edges too. The held frame is checked one full word sequence after the stall began. The release is checked one cycle after `out_ready` rises. The sweep puts every nonzero value into each of the 22 symbol positions alone, then adds random frames. Expected parity comes from long division using log and antilog tables, and syndromes are recomputed in the bench.

// File: rtl/rs_frame_encoder.sv
module rs_frame_encoder (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_sof,
  input  logic [29:0]  in_data,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [119:0] out_frame
);
  localparam int WORD_W   = 30;
  localparam int N_WORDS  = 4;
  localparam int FRAME_W  = WORD_W * N_WORDS;
  localparam int SYM_W    = 4;
  localparam int MSG_SYMS = 22;
  localparam int MSG_W    = MSG_SYMS * SYM_W;
  localparam int SLICE_W  = MSG_W / N_WORDS;
  localparam int PAR_W    = FRAME_W - MSG_W;
  localparam logic [3:0] G3 = 4'hD, G2 = 4'hC, G1 = 4'h8, G0 = 4'h7;

  logic [1:0]         cnt, idx;
  logic [SLICE_W-1:0] w0, w1, w2;
  logic [MSG_W-1:0]   msg;
  logic               done, load;

  function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) p = p ^ x;
      x = {x[2:0], 1'b0} ^ (x[3] ? 4'h3 : 4'h0);
    end
    return p;
  endfunction

  function automatic logic [15:0] lfsr_step(input logic [15:0] r, input logic [3:0] s);
    logic [3:0] fb;
    fb = s ^ r[15:12];
    return {r[11:8] ^ gf_mul(fb, G3), r[7:4] ^ gf_mul(fb, G2),
            r[3:0] ^ gf_mul(fb, G1), gf_mul(fb, G0)};
  endfunction

  function automatic logic [PAR_W-1:0] rs_parity(input logic [MSG_W-1:0] m);
    logic [15:0] ra, rb;
    ra = '0;
    rb = '0;
    for (int j = 0; j < MSG_SYMS; j++) begin
      if (j % 2 == 0) ra = lfsr_step(ra, m[MSG_W-1-SYM_W*j -: SYM_W]);
      else            rb = lfsr_step(rb, m[MSG_W-1-SYM_W*j -: SYM_W]);
    end
    return {ra[15:12], rb[15:12], ra[11:8], rb[11:8], ra[7:4], rb[7:4], ra[3:0], rb[3:0]};
  endfunction

  assign idx  = in_sof ? 2'd0 : cnt;
  assign done = in_valid && (idx == 2'd3);
  assign load = done && (!out_valid || out_ready);
  assign msg  = {w0, w1, w2, in_data[SLICE_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      w0        <= '0;
      w1        <= '0;
      w2        <= '0;
      out_valid <= 1'b0;
      out_frame <= '0;
    end else begin
      if (in_valid) begin
        cnt <= idx + 2'd1;
        case (idx)
          2'd0:    w0 <= in_data[SLICE_W-1:0];
          2'd1:    w1 <= in_data[SLICE_W-1:0];
          2'd2:    w2 <= in_data[SLICE_W-1:0];
          default: ;
        endcase
      end
      if (load) begin
        out_frame <= {msg, rs_parity(msg)};
        out_valid <= 1'b1;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  function automatic logic syndromes_zero(input logic [FRAME_W-1:0] f);
    logic [3:0] root, acc;
    logic ok;
    ok   = 1'b1;
    root = 4'h1;
    for (int i = 1; i <= 4; i++) begin
      root = gf_mul(root, 4'h2);
      for (int k = 0; k < 2; k++) begin
        acc = '0;
        for (int j = 0; j < 15; j++)
          acc = gf_mul(acc, root) ^ f[FRAME_W-1-SYM_W*(2*j+k) -: SYM_W];
        if (acc != 4'h0) ok = 1'b0;
      end
    end
    return ok;
  endfunction

  a_r5_zero_syndromes: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> syndromes_zero(out_frame));

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_frame));

  a_r6_frame_on_fourth_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && !in_sof));

  a_r8_handshake_clear: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
endmodule

// File: tb/rs_frame_encoder_test.sv
`timescale 1ns/1ps
module rs_frame_encoder_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_sof = 1'b0;
  logic [29:0]  in_data = '0;
  logic         out_ready = 1'b1;
  logic         out_valid;
  logic [119:0] out_frame;

  int total = 0;
  int bad = 0;
  logic [3:0] exp_t [0:14];
  int         log_t [0:15];
  logic [3:0] g [0:4];

  rs_frame_encoder uut (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_data(in_data), .out_ready(out_ready), .out_valid(out_valid), .out_frame(out_frame));

  always #2 clk = ~clk;

  initial begin
    #800000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  function automatic logic [3:0] gm(input logic [3:0] a, input logic [3:0] b);
    if (a == 0 || b == 0) return 4'h0;
    return exp_t[(log_t[a] + log_t[b]) % 15];
  endfunction

  function automatic logic [15:0] parity_of(input logic [87:0] m, input int k);
    logic [3:0] r [0:14];
    logic [3:0] c;
    for (int d = 0; d < 15; d++) r[d] = 4'h0;
    for (int j = 0; j < 11; j++) r[14-j] = m[87-4*(2*j+k) -: 4];
    for (int d = 14; d >= 4; d--) begin
      c = r[d];
      for (int t = 0; t <= 4; t++) r[d-4+t] = r[d-4+t] ^ gm(c, g[t]);
    end
    return {r[3], r[2], r[1], r[0]};
  endfunction

  function automatic logic [119:0] model(input logic [87:0] m);
    logic [15:0] pa, pb;
    pa = parity_of(m, 0);
    pb = parity_of(m, 1);
    return {m, pa[15:12], pb[15:12], pa[11:8], pb[11:8], pa[7:4], pb[7:4], pa[3:0], pb[3:0]};
  endfunction

  function automatic bit synd_zero(input logic [119:0] f);
    logic [3:0] acc;
    for (int i = 1; i <= 4; i++)
      for (int k = 0; k < 2; k++) begin
        acc = 4'h0;
        for (int j = 0; j < 15; j++) acc = gm(acc, exp_t[i]) ^ f[119-4*(2*j+k) -: 4];
        if (acc != 0) return 1'b0;
      end
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input logic [119:0] act, input logic [119:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic push_word(input logic [21:0] slice, input logic sof);
    @(negedge clk);
    in_valid = 1'b1;
    in_sof   = sof;
    in_data  = {8'($urandom), slice};
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_data  = 30'($urandom);
  endtask

  task automatic push_frame(input logic [87:0] m);
    push_word(m[87:66], 1'b1);
    push_word(m[65:44], 1'b0);
    push_word(m[43:22], 1'b0);
    push_word(m[21:0], 1'b0);
  endtask

  task automatic run_frame(input logic [87:0] m, input string tag);
    logic [119:0] e;
    e = model(m);
    push_frame(m);
    check(out_valid === 1'b1, {"R7 valid ", tag}, {119'b0, out_valid}, 120'd1);
    check(out_frame === e, {"R2 R3 R4 frame ", tag}, out_frame, e);
    check(synd_zero(out_frame), {"R5 syndromes ", tag}, out_frame, e);
  endtask

  initial begin
    logic [87:0] m, m1, m2;
    logic [119:0] e1;
    exp_t[0] = 4'h1;
    for (int i = 1; i < 15; i++)
      exp_t[i] = {exp_t[i-1][2:0], 1'b0} ^ (exp_t[i-1][3] ? 4'h3 : 4'h0);
    log_t[0] = 0;
    for (int i = 0; i < 15; i++) log_t[exp_t[i]] = i;
    g[0] = 4'h1;
    for (int t = 1; t <= 4; t++) g[t] = 4'h0;
    for (int i = 1; i <= 4; i++) begin
      for (int t = 4; t >= 1; t--) g[t] = g[t-1] ^ gm(g[t], exp_t[i]);
      g[0] = gm(g[0], exp_t[i]);
    end

    repeat (3) @(negedge clk);
    check(out_valid === 1'b0 && out_frame === '0, "R1 in reset", out_frame, '0);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0 && out_frame === '0, "R1 after reset", out_frame, '0);

    // R2 R3 R4 R5: each symbol position alone with every nonzero value
    for (int p = 0; p < 22; p++)
      for (int v = 1; v < 16; v++) begin
        m = '0;
        m[87-4*p -: 4] = 4'(v);
        run_frame(m, "sweep");
      end
    for (int n = 0; n < 40; n++) begin
      m = {24'($urandom), 32'($urandom), 32'($urandom)};
      run_frame(m, "random");
    end

    // R6: partial frame gives no output, and a new start discards it
    m1 = {24'($urandom), 32'($urandom), 32'($urandom)};
    push_word(m1[87:66], 1'b1);
    push_word(m1[65:44], 1'b0);
    push_word(m1[43:22], 1'b0);
    check(out_valid === 1'b0, "R6 three words no frame", {119'b0, out_valid}, '0);
    m = {24'($urandom), 32'($urandom), 32'($urandom)};
    run_frame(m, "R6 resync");

    // R2: upper word bits have no effect (push_frame randomizes them)
    m2 = {24'($urandom), 32'($urandom), 32'($urandom)};
    run_frame(m2, "R2 upper bits a");
    run_frame(m2, "R2 upper bits b");

    // R7 R8: stall holds the frame and drops one that completes meanwhile
    @(negedge clk);
    out_ready = 1'b0;
    m1 = {24'($urandom), 32'($urandom), 32'($urandom)};
    e1 = model(m1);
    push_frame(m1);
    check(out_valid === 1'b1 && out_frame === e1, "R7 stalled frame", out_frame, e1);
    m2 = ~m1;
    push_frame(m2);
    check(out_valid === 1'b1, "R7 still valid", {119'b0, out_valid}, 120'd1);
    check(out_frame === e1, "R8 dropped while stalled", out_frame, e1);
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R8 release clears valid", {119'b0, out_valid}, '0);
    check(out_frame === e1, "R8 frame unchanged after release", out_frame, e1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule